// File: doc/BRIEF.md
# Double-Buffered Signaling Byte Buffer

This block carries per-channel signaling bytes between a controller register port and a framed line datapath. Each direction holds two byte arrays of equal depth. One is a staging array that one side fills. The other is a live array that the other side drains. An update strobe copies the whole staging array into the live array in a single clock. The fill side and the drain side therefore never share an array.

In the transmit direction, the controller writes the staging array through an auto-incrementing pointer. The line side reads the live array one slot at a time, starting again at slot 1 on every transmit frame start. In the receive direction, the line side fills the staging array, restarting at slot 1 on every receive frame start. The controller reads the live array through its own auto-incrementing pointer.

Each direction has a rate monitor. It raises a sticky underflow flag when the live array is consumed twice with no update in between. It raises a sticky overflow flag when the array is updated twice with no consumption in between. A status-read strobe clears all four flags. The flags are ORed into one signaling-error interrupt. A separate load interrupt pulses once per transmit frame.

Top module: `sig_dbuf_top`

## Requirements
- R1: After reset, all pointers sit at slot 1 and every array byte is 0x00, so `tx_slot_data` and `cpu_rx_rdata` read 0x00. All four flags and both interrupts are low.
- R2: A pulse on a pointer-reset strobe returns that pointer to slot 1 whatever its position. These strobes are `cpu_tx_ptr_rst` (controller write pointer), `cpu_rx_ptr_rst` (controller read pointer), `tx_frame_start` (line read pointer) and `rx_frame_start` (line write pointer).
- R3: Each write or read strobe acts on the slot under its pointer and then advances the pointer by one. After slot DEPTH (48) the pointer returns to slot 1, so a 49th write overwrites slot 1 and a 49th read returns slot 1.
- R4: An update strobe copies every staging byte into the live array on one clock edge. Staging writes made after an update do not appear on the live side until the next update.
- R5: In the receive direction, bytes written by `rx_slot_wr` after `rx_frame_start` appear on `cpu_rx_rdata` in slot order once `cpu_rx_update` has been pulsed and `cpu_rx_ptr_rst` has restarted the read pointer.
- R6: The underflow flag of a direction sets when a consumption occurs and the previous consumption has not been followed by an update. Transmit consumption is `tx_frame_start`. Receive consumption is `cpu_rx_ptr_rst`. The first consumption after reset never flags.
- R7: The overflow flag of a direction sets when an update occurs and the previous update has not been followed by a consumption. The first update after reset never flags.
- R8: An update and a consumption in the same cycle raise neither flag. They count as an update followed by a consumption. A later lone consumption then underflows, and a later lone update does not overflow.
- R9: Flags stay set until `cpu_stat_rd` is pulsed, which clears all four. An error event in the same cycle as `cpu_stat_rd` leaves its flag set.
- R10: `sig_err_irq` is the OR of the four flags. `tx_load_irq` is high for exactly the one cycle after each `tx_frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wdata | input | 8 | Controller write byte |
| cpu_tx_wr | input | 1 | Controller write to transmit staging array |
| cpu_tx_ptr_rst | input | 1 | Return transmit controller pointer to slot 1 |
| cpu_tx_update | input | 1 | Copy transmit staging to transmit live array |
| cpu_rx_rd | input | 1 | Controller read strobe, advances receive read pointer |
| cpu_rx_ptr_rst | input | 1 | Return receive controller pointer to slot 1 (receive consumption) |
| cpu_rx_update | input | 1 | Copy receive staging to receive live array |
| cpu_rx_rdata | output | 8 | Receive live byte under controller pointer |
| cpu_stat_rd | input | 1 | Status read, clears all flags |
| tx_frame_start | input | 1 | Transmit frame start (transmit consumption) |
| tx_slot_rd | input | 1 | Line read strobe, advances transmit line pointer |
| tx_slot_data | output | 8 | Transmit live byte under line pointer |
| rx_frame_start | input | 1 | Receive frame start, restarts line write pointer |
| rx_slot_wr | input | 1 | Line write to receive staging array |
| rx_slot_data | input | 8 | Line write byte |
| tx_under | output | 1 | Transmit underflow flag |
| tx_over | output | 1 | Transmit overflow flag |
| rx_under | output | 1 | Receive underflow flag |
| rx_over | output | 1 | Receive overflow flag |
| sig_err_irq | output | 1 | OR of the four flags |
| tx_load_irq | output | 1 | One-cycle pulse after each transmit frame start |

## Verification
An update and a consumption of the live array can fall in the same clock. This can also coincide with a status read that clears the flags. The bench provokes both cases by pulsing `cpu_tx_update` together with `tx_frame_start`, and `cpu_stat_rd` together with a second frame start, from a table of cycle vectors. It judges the result by the flag values after that edge, and by whether the following lone consumption or lone update raises a flag as the ordering rule predicts.

// File: rtl/sig_dbuf_pkg.sv
package sig_dbuf_pkg;

   localparam int unsigned SIG_DEPTH_DEF = 48;
   localparam int unsigned SIG_WIDTH_DEF = 8;

   // pointer width for a given depth, never below one bit
   function automatic int unsigned ptr_bits(input int unsigned depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

   // per-direction rate history
   typedef struct packed {
      logic upd_pend;   // update seen, not yet consumed
      logic use_pend;   // consumed, not yet refreshed
   } rate_hist_t;

endpackage

// File: rtl/sig_ptr_ctr.sv
module sig_ptr_ctr
   import sig_dbuf_pkg::*;
#(
   parameter int unsigned DEPTH = SIG_DEPTH_DEF,
   localparam int unsigned PW   = ptr_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   output logic [PW-1:0] ptr
);

   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   initial begin : prm_chk
      assert (DEPTH >= 2) else $fatal(1, "sig_ptr_ctr: DEPTH must be at least 2");
   end

   logic [PW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ptr_q <= '0;
      else if (clr)        ptr_q <= '0;
      else if (step) begin
         if (ptr_q == LAST) ptr_q <= '0;
         else               ptr_q <= ptr_q + 1'b1;
      end
   end

   assign ptr = ptr_q;

   // R2
   ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ptr == '0));

   // R3
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && ptr == LAST) |=> (ptr == '0));

   // R3
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));

   // R3
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);

endmodule

// File: rtl/sig_buf_pair.sv
module sig_buf_pair
   import sig_dbuf_pkg::*;
#(
   parameter int unsigned DEPTH = SIG_DEPTH_DEF,
   parameter int unsigned WIDTH = SIG_WIDTH_DEF,
   localparam int unsigned PW   = ptr_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PW-1:0]    wr_idx,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             copy,
   input  logic [PW-1:0]    rd_idx,
   output logic [WIDTH-1:0] rd_data
);

   initial begin : prm_chk
      assert (WIDTH >= 1) else $fatal(1, "sig_buf_pair: WIDTH must be positive");
      assert (DEPTH >= 2) else $fatal(1, "sig_buf_pair: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [DEPTH];
   logic [WIDTH-1:0] live_q  [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      localparam logic [PW-1:0] IDX = PW'(e);

      // staging slot: written by the fill side
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     stage_q[e] <= '0;
         else if (wr_en && wr_idx == IDX) stage_q[e] <= wr_data;
      end

      // live slot: refreshed only by the handoff copy
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    live_q[e] <= '0;
         else if (copy) live_q[e] <= stage_q[e];
      end
   end

   assign rd_data = live_q[rd_idx];

   // R4
   copy_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy |=> (live_q[0] == $past(stage_q[0])));

   // R4
   copy_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy |=> (live_q[DEPTH-1] == $past(stage_q[DEPTH-1])));

   // R4
   live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !copy |=> $stable(live_q[0]));

endmodule

// File: rtl/sig_rate_mon.sv
module sig_rate_mon
   import sig_dbuf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic update,
   input  logic consume,
   input  logic clr,
   output logic under,
   output logic over
);

   rate_hist_t hist_q, hist_d;
   logic       under_q, over_q;
   logic       under_evt, over_evt;

   // an update and a consumption together count as update then consume
   assign under_evt = consume && hist_q.use_pend && !update;
   assign over_evt  = update  && hist_q.upd_pend && !consume;

   always_comb begin
      hist_d = hist_q;
      if (update && consume) begin
         hist_d.upd_pend = 1'b0;
         hist_d.use_pend = 1'b1;
      end else if (update) begin
         hist_d.upd_pend = 1'b1;
         hist_d.use_pend = 1'b0;
      end else if (consume) begin
         hist_d.upd_pend = 1'b0;
         hist_d.use_pend = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q  <= '0;
         under_q <= 1'b0;
         over_q  <= 1'b0;
      end else begin
         hist_q  <= hist_d;
         under_q <= under_evt || (under_q && !clr);
         over_q  <= over_evt  || (over_q  && !clr);
      end
   end

   assign under = under_q;
   assign over  = over_q;

   // R6
   under_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && !update && $past(consume) && !$past(update)) |=> under);

   // R7
   over_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (update && !consume && $past(update) && !$past(consume)) |=> over);

   // R8
   coincide_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (update && consume && clr) |=> (!under && !over));

   // R9
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (under && !clr) |=> under);

   // R9
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !update && !consume) |=> (!under && !over));

endmodule

// File: rtl/sig_dir_chan.sv
module sig_dir_chan
   import sig_dbuf_pkg::*;
#(
   parameter int unsigned DEPTH = SIG_DEPTH_DEF,
   parameter int unsigned WIDTH = SIG_WIDTH_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_clr,
   input  logic             fill_stb,
   input  logic [WIDTH-1:0] fill_data,
   input  logic             drain_clr,
   input  logic             drain_stb,
   output logic [WIDTH-1:0] drain_data,
   input  logic             update,
   input  logic             consume,
   input  logic             stat_clr,
   output logic             under,
   output logic             over
);

   localparam int unsigned PW = ptr_bits(DEPTH);

   logic [PW-1:0] fill_ptr, drain_ptr;

   sig_ptr_ctr #(.DEPTH(DEPTH)) u_fill_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (fill_clr),
      .step  (fill_stb),
      .ptr   (fill_ptr)
   );

   sig_ptr_ctr #(.DEPTH(DEPTH)) u_drain_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (drain_clr),
      .step  (drain_stb),
      .ptr   (drain_ptr)
   );

   sig_buf_pair #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bufs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (fill_stb),
      .wr_idx  (fill_ptr),
      .wr_data (fill_data),
      .copy    (update),
      .rd_idx  (drain_ptr),
      .rd_data (drain_data)
   );

   sig_rate_mon u_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .update  (update),
      .consume (consume),
      .clr     (stat_clr),
      .under   (under),
      .over    (over)
   );

endmodule

// File: rtl/sig_dbuf_top.sv
module sig_dbuf_top
   import sig_dbuf_pkg::*;
#(
   parameter int unsigned DEPTH = SIG_DEPTH_DEF,
   parameter int unsigned WIDTH = SIG_WIDTH_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cpu_wdata,
   input  logic             cpu_tx_wr,
   input  logic             cpu_tx_ptr_rst,
   input  logic             cpu_tx_update,
   input  logic             cpu_rx_rd,
   input  logic             cpu_rx_ptr_rst,
   input  logic             cpu_rx_update,
   output logic [WIDTH-1:0] cpu_rx_rdata,
   input  logic             cpu_stat_rd,
   input  logic             tx_frame_start,
   input  logic             tx_slot_rd,
   output logic [WIDTH-1:0] tx_slot_data,
   input  logic             rx_frame_start,
   input  logic             rx_slot_wr,
   input  logic [WIDTH-1:0] rx_slot_data,
   output logic             tx_under,
   output logic             tx_over,
   output logic             rx_under,
   output logic             rx_over,
   output logic             sig_err_irq,
   output logic             tx_load_irq
);

   // transmit: controller fills, line drains once per frame
   sig_dir_chan #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_clr   (cpu_tx_ptr_rst),
      .fill_stb   (cpu_tx_wr),
      .fill_data  (cpu_wdata),
      .drain_clr  (tx_frame_start),
      .drain_stb  (tx_slot_rd),
      .drain_data (tx_slot_data),
      .update     (cpu_tx_update),
      .consume    (tx_frame_start),
      .stat_clr   (cpu_stat_rd),
      .under      (tx_under),
      .over       (tx_over)
   );

   // receive: line fills per frame, controller drains per read pass
   sig_dir_chan #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_clr   (rx_frame_start),
      .fill_stb   (rx_slot_wr),
      .fill_data  (rx_slot_data),
      .drain_clr  (cpu_rx_ptr_rst),
      .drain_stb  (cpu_rx_rd),
      .drain_data (cpu_rx_rdata),
      .update     (cpu_rx_update),
      .consume    (cpu_rx_ptr_rst),
      .stat_clr   (cpu_stat_rd),
      .under      (rx_under),
      .over       (rx_over)
   );

   logic load_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_q <= 1'b0;
      else        load_q <= tx_frame_start;
   end

   assign tx_load_irq = load_q;
   assign sig_err_irq = tx_under | tx_over | rx_under | rx_over;

   // R10
   load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_frame_start |=> tx_load_irq);

   // R10
   load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_frame_start |=> !tx_load_irq);

   // R10
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_under) |-> sig_err_irq);

endmodule

// File: tb/sig_dbuf_top_test.sv
module sig_dbuf_top_test;

   localparam int DEPTH = 48;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic       cpu_tx_wr = 0, cpu_tx_ptr_rst = 0, cpu_tx_update = 0;
   logic       cpu_rx_rd = 0, cpu_rx_ptr_rst = 0, cpu_rx_update = 0;
   logic [7:0] cpu_rx_rdata;
   logic       cpu_stat_rd = 0;
   logic       tx_frame_start = 0, tx_slot_rd = 0;
   logic [7:0] tx_slot_data;
   logic       rx_frame_start = 0, rx_slot_wr = 0;
   logic [7:0] rx_slot_data = '0;
   logic       tx_under, tx_over, rx_under, rx_over, sig_err_irq, tx_load_irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sig_dbuf_top uut (
      .clk(clk), .rst_n(rst_n), .cpu_wdata(cpu_wdata),
      .cpu_tx_wr(cpu_tx_wr), .cpu_tx_ptr_rst(cpu_tx_ptr_rst), .cpu_tx_update(cpu_tx_update),
      .cpu_rx_rd(cpu_rx_rd), .cpu_rx_ptr_rst(cpu_rx_ptr_rst), .cpu_rx_update(cpu_rx_update),
      .cpu_rx_rdata(cpu_rx_rdata), .cpu_stat_rd(cpu_stat_rd),
      .tx_frame_start(tx_frame_start), .tx_slot_rd(tx_slot_rd), .tx_slot_data(tx_slot_data),
      .rx_frame_start(rx_frame_start), .rx_slot_wr(rx_slot_wr), .rx_slot_data(rx_slot_data),
      .tx_under(tx_under), .tx_over(tx_over), .rx_under(rx_under), .rx_over(rx_over),
      .sig_err_irq(sig_err_irq), .tx_load_irq(tx_load_irq)
   );

   // {tx update, tx frame start, status read, expected under, expected over}
   localparam logic [4:0] FLAG_VEC [12] = '{
      5'b01000,  // first consumption: quiet (R6)
      5'b01010,  // second consumption: underflow (R6)
      5'b10010,  // update: underflow stays (R9)
      5'b10011,  // second update: overflow (R7)
      5'b00100,  // status read clears (R9)
      5'b11000,  // update with consumption: quiet (R8)
      5'b01010,  // lone consumption afterwards underflows (R8)
      5'b01110,  // clear with new underflow: set wins (R9)
      5'b00100,  // clear
      5'b10000,  // update: quiet
      5'b01000,  // consumption after update: quiet
      5'b10000   // update after consumption: quiet (R7)
   };

   function automatic logic [7:0] txb(input int i);
      return 8'((i * 7) + 3);
   endfunction

   function automatic logic [7:0] rxb(input int i);
      return 8'((i * 13) + 8'h40);
   endfunction

   task automatic tick;
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      tick();

      // R1 reset state
      chk("R1 tx_slot_data", tx_slot_data, 8'h00);
      chk("R1 cpu_rx_rdata", cpu_rx_rdata, 8'h00);
      chk("R1 flags", {tx_under, tx_over, rx_under, rx_over}, 4'b0000);
      chk("R1 irqs", {sig_err_irq, tx_load_irq}, 2'b00);

      // flag table walk (R6 R7 R8 R9 R10)
      for (int k = 0; k < 12; k++) begin
         cpu_tx_update  = FLAG_VEC[k][4];
         tx_frame_start = FLAG_VEC[k][3];
         cpu_stat_rd    = FLAG_VEC[k][2];
         tick();
         cpu_tx_update = 0; tx_frame_start = 0; cpu_stat_rd = 0;
         chk($sformatf("R6/R7/R8/R9 vec %0d flags", k), {tx_under, tx_over}, FLAG_VEC[k][1:0]);
         chk($sformatf("R10 vec %0d err irq", k), sig_err_irq, |FLAG_VEC[k][1:0]);
      end

      // R10 load interrupt pulse width
      tx_frame_start = 1; tick(); tx_frame_start = 0;
      chk("R10 load pulse", tx_load_irq, 1'b1);
      tick();
      chk("R10 load pulse ends", tx_load_irq, 1'b0);

      // R2/R3/R4 transmit fill, handoff, drain
      cpu_tx_ptr_rst = 1; tick(); cpu_tx_ptr_rst = 0;
      for (int i = 0; i < DEPTH; i++) begin
         cpu_wdata = txb(i); cpu_tx_wr = 1; tick();
      end
      cpu_tx_wr = 0;
      chk("R4 live unchanged before update", tx_slot_data, 8'h00);
      cpu_tx_update = 1; tick(); cpu_tx_update = 0;
      tx_frame_start = 1; tick(); tx_frame_start = 0;
      for (int i = 0; i < DEPTH; i++) begin
         chk($sformatf("R4 tx slot %0d", i + 1), tx_slot_data, txb(i));
         tx_slot_rd = 1; tick(); tx_slot_rd = 0;
      end
      chk("R3 tx read wrap", tx_slot_data, txb(0));

      // R3 write wrap: 49th write lands on slot 1, and R4 isolation
      cpu_tx_ptr_rst = 1; tick(); cpu_tx_ptr_rst = 0;
      for (int i = 0; i < DEPTH; i++) begin
         cpu_wdata = txb(i); cpu_tx_wr = 1; tick();
      end
      cpu_wdata = 8'h5C; tick(); cpu_tx_wr = 0;
      chk("R4 staging write hidden", tx_slot_data, txb(0));
      cpu_tx_update = 1; tick(); cpu_tx_update = 0;
      tx_frame_start = 1; tick(); tx_frame_start = 0;
      chk("R3 write wrap slot 1", tx_slot_data, 8'h5C);
      tx_slot_rd = 1; tick(); tx_slot_rd = 0;
      chk("R3 slot 2 kept", tx_slot_data, txb(1));

      // R2 pointer reset from mid-array
      cpu_tx_ptr_rst = 1; tick(); cpu_tx_ptr_rst = 0;
      cpu_wdata = 8'h11; cpu_tx_wr = 1; tick();
      cpu_wdata = 8'h22; tick();
      cpu_tx_ptr_rst = 1; cpu_tx_wr = 0; tick(); cpu_tx_ptr_rst = 0;
      cpu_wdata = 8'hAA; cpu_tx_wr = 1; tick(); cpu_tx_wr = 0;
      cpu_tx_update = 1; tick(); cpu_tx_update = 0;
      tx_frame_start = 1; tick(); tx_frame_start = 0;
      chk("R2 tx slot 1 after ptr reset", tx_slot_data, 8'hAA);
      tx_slot_rd = 1; tick(); tx_slot_rd = 0;
      chk("R2 tx slot 2 kept", tx_slot_data, 8'h22);

      cpu_stat_rd = 1; tick(); cpu_stat_rd = 0;
      chk("R9 rx flags clear", {rx_under, rx_over}, 2'b00);

      // R5 receive path
      rx_frame_start = 1; tick(); rx_frame_start = 0;
      for (int i = 0; i < DEPTH; i++) begin
         rx_slot_data = rxb(i); rx_slot_wr = 1; tick();
      end
      rx_slot_wr = 0;
      cpu_rx_update = 1; tick(); cpu_rx_update = 0;
      cpu_rx_ptr_rst = 1; tick(); cpu_rx_ptr_rst = 0;
      chk("R6 rx first consumption quiet", rx_under, 1'b0);
      for (int i = 0; i < DEPTH; i++) begin
         chk($sformatf("R5 rx slot %0d", i + 1), cpu_rx_rdata, rxb(i));
         cpu_rx_rd = 1; tick(); cpu_rx_rd = 0;
      end
      chk("R3 rx read wrap", cpu_rx_rdata, rxb(0));

      // R6 rx underflow, R7 rx overflow
      cpu_rx_ptr_rst = 1; tick(); cpu_rx_ptr_rst = 0;
      chk("R6 rx underflow", {rx_under, rx_over}, 2'b10);
      cpu_rx_update = 1; tick(); cpu_rx_update = 0;
      chk("R7 rx first update quiet", rx_over, 1'b0);
      cpu_rx_update = 1; tick(); cpu_rx_update = 0;
      chk("R7 rx overflow", {rx_under, rx_over}, 2'b11);
      chk("R10 err irq from rx", sig_err_irq, 1'b1);
      cpu_stat_rd = 1; tick(); cpu_stat_rd = 0;
      chk("R9 all clear", {tx_under, tx_over, rx_under, rx_over, sig_err_irq}, 5'b00000);

      finish_run();
   end

endmodule